// File: doc/BRIEF.md
# Cascadable Magnitude Comparator with Min/Max Select

This block compares two unsigned operands. It is built from 4-bit comparator slices. Each slice compares its own nibble of the two operands. When the two nibbles are equal, the slice passes on the verdict it receives from the slice below it. The slices chain from the least significant nibble to the most significant one, so the most significant nibble that differs decides the result. With the default parameters, three slices form a 12-bit comparator.

The less/equal/greater cascade inputs of the lowest slice are brought out to the ports. A wider comparison can therefore continue from a lower-order comparator. For a standalone compare, the caller drives equal=1 and less=greater=0.

The chain's final greater-than result also drives a two-way selector. That selector returns the larger or the smaller operand, according to a mode input. The block is purely combinational.

Top module: `mag_cmp_minmax`

## Requirements
- R1: `gt_o` is 1 exactly when `a_i > b_i` (unsigned), or when `a_i == b_i` and `cas_gt_i` is 1.
- R2: `lt_o` is 1 exactly when `a_i < b_i` (unsigned), or when `a_i == b_i` and `cas_lt_i` is 1.
- R3: `eq_o` is 1 exactly when `a_i == b_i` and `cas_eq_i` is 1.
- R4: Only the most significant differing nibble decides `gt_o` and `lt_o`; any values in the lower nibbles leave the result unchanged.
- R5: When exactly one of `cas_lt_i`, `cas_eq_i` and `cas_gt_i` is 1, exactly one of `lt_o`, `eq_o` and `gt_o` is 1. When all three cascade inputs are 0 and the operands are equal, all three flags are 0.
- R6: With `max_mode_i` = 1, `sel_o` equals the larger of `a_i` and `b_i`, for any cascade input values.
- R7: With `max_mode_i` = 0, `sel_o` equals the smaller of `a_i` and `b_i`, for any cascade input values.
- R8: When `a_i == b_i`, `sel_o` equals that common value in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | DATA_W (12) | First unsigned operand |
| b_i | input | DATA_W (12) | Second unsigned operand |
| cas_lt_i | input | 1 | Cascade less-than in, to the lowest slice |
| cas_eq_i | input | 1 | Cascade equal in, to the lowest slice |
| cas_gt_i | input | 1 | Cascade greater-than in, to the lowest slice |
| max_mode_i | input | 1 | 1 selects the larger operand, 0 the smaller |
| lt_o | output | 1 | a_i below b_i (or equal with cascade less) |
| eq_o | output | 1 | a_i equals b_i and cascade equal |
| gt_o | output | 1 | a_i above b_i (or equal with cascade greater) |
| sel_o | output | DATA_W (12) | Selected minimum or maximum operand |

## Verification
The assertions assume that all inputs carry known 0/1 values. They check the flags against the unsigned relational operators for every cascade input combination. The one-hot property is checked only when the cascade inputs are themselves one-hot, because a multi-hot cascade input can legally produce multi-hot flags when the operands are equal. The stimulus always drives every input to a defined value. Most vectors use a single one-hot cascade input. A smaller set sweeps all eight cascade combinations over equal operand pairs, which is the only case where the cascade inputs matter.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;
endpackage

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICE_W = 4
) (
  input  logic [SLICE_W-1:0] a_i,
  input  logic [SLICE_W-1:0] b_i,
  input  rel_t               rel_i,
  output rel_t               rel_o
);
  // prefix_eq[k]: all bits above k-1 match; scanned from the MSB down
  logic [SLICE_W:0]   prefix_eq;
  logic [SLICE_W-1:0] gt_term;
  logic [SLICE_W-1:0] lt_term;
  logic               loc_gt, loc_lt, loc_eq;

  assign prefix_eq[SLICE_W] = 1'b1;

  for (genvar i = SLICE_W - 1; i >= 0; i--) begin : g_bit
    assign gt_term[i]   = prefix_eq[i+1] & a_i[i] & ~b_i[i];
    assign lt_term[i]   = prefix_eq[i+1] & ~a_i[i] & b_i[i];
    assign prefix_eq[i] = prefix_eq[i+1] & ~(a_i[i] ^ b_i[i]);
  end

  assign loc_gt = |gt_term;
  assign loc_lt = |lt_term;
  assign loc_eq = prefix_eq[0];

  assign rel_o.gt = loc_gt | (loc_eq & rel_i.gt);
  assign rel_o.lt = loc_lt | (loc_eq & rel_i.lt);
  assign rel_o.eq = loc_eq & rel_i.eq;
endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 3,
  localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  rel_t              rel_i,
  output rel_t              rel_o
);
  rel_t link [NUM_SLICES+1];

  assign link[0] = rel_i;

  // slice 0 takes the least significant nibble; higher slices override
  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    mag_cmp_slice #(.SLICE_W(SLICE_W)) u_slice (
      .a_i  (a_i[s*SLICE_W +: SLICE_W]),
      .b_i  (b_i[s*SLICE_W +: SLICE_W]),
      .rel_i(link[s]),
      .rel_o(link[s+1])
    );
  end

  assign rel_o = link[NUM_SLICES];
endmodule

// File: rtl/mag_cmp_sel.sv
module mag_cmp_sel #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              a_gt_b_i,
  input  logic              max_mode_i,
  output logic [DATA_W-1:0] sel_o
);
  logic take_a;

  // when the operands are equal either choice gives the same value
  assign take_a = max_mode_i ? a_gt_b_i : ~a_gt_b_i;
  assign sel_o  = take_a ? a_i : b_i;
endmodule

// File: rtl/mag_cmp_minmax.sv
module mag_cmp_minmax
  import mag_cmp_pkg::*;
#(
  parameter int unsigned SLICE_W    = 4,
  parameter int unsigned NUM_SLICES = 3,
  localparam int unsigned DATA_W    = SLICE_W * NUM_SLICES
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cas_lt_i,
  input  logic              cas_eq_i,
  input  logic              cas_gt_i,
  input  logic              max_mode_i,
  output logic              lt_o,
  output logic              eq_o,
  output logic              gt_o,
  output logic [DATA_W-1:0] sel_o
);
  rel_t rel_in, rel_out;

  assign rel_in = '{lt: cas_lt_i, eq: cas_eq_i, gt: cas_gt_i};

  mag_cmp_chain #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chain (
    .a_i  (a_i),
    .b_i  (b_i),
    .rel_i(rel_in),
    .rel_o(rel_out)
  );

  mag_cmp_sel #(.DATA_W(DATA_W)) u_sel (
    .a_i       (a_i),
    .b_i       (b_i),
    .a_gt_b_i  (rel_out.gt),
    .max_mode_i(max_mode_i),
    .sel_o     (sel_o)
  );

  assign lt_o = rel_out.lt;
  assign eq_o = rel_out.eq;
  assign gt_o = rel_out.gt;
endmodule

// File: rtl/mag_cmp_minmax_chk.sv
module mag_cmp_minmax_chk #(
  parameter int unsigned DATA_W = 12
) (
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              cas_lt_i,
  input logic              cas_eq_i,
  input logic              cas_gt_i,
  input logic              max_mode_i,
  input logic              lt_o,
  input logic              eq_o,
  input logic              gt_o,
  input logic [DATA_W-1:0] sel_o
);
  always_comb begin
    AST_GT_FLAG: assert (gt_o == ((a_i > b_i) || ((a_i == b_i) && cas_gt_i)));  // R1
    AST_LT_FLAG: assert (lt_o == ((a_i < b_i) || ((a_i == b_i) && cas_lt_i)));  // R2
    AST_EQ_FLAG: assert (eq_o == ((a_i == b_i) && cas_eq_i));  // R3
    if ($onehot({cas_lt_i, cas_eq_i, cas_gt_i}))
      AST_ONEHOT_OUT: assert ($onehot({lt_o, eq_o, gt_o}));  // R5
    if (max_mode_i)
      AST_MAX_SEL: assert (sel_o == ((a_i > b_i) ? a_i : b_i));  // R6
    else
      AST_MIN_SEL: assert (sel_o == ((a_i < b_i) ? a_i : b_i));  // R7
    if (a_i == b_i)
      AST_EQUAL_SEL: assert (sel_o == a_i);  // R8
  end
endmodule

bind mag_cmp_minmax mag_cmp_minmax_chk #(.DATA_W(DATA_W)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cas_lt_i  (cas_lt_i),
  .cas_eq_i  (cas_eq_i),
  .cas_gt_i  (cas_gt_i),
  .max_mode_i(max_mode_i),
  .lt_o      (lt_o),
  .eq_o      (eq_o),
  .gt_o      (gt_o),
  .sel_o     (sel_o)
);

// File: tb/mag_cmp_minmax_tb.sv
`timescale 1ns/1ps
module mag_cmp_minmax_tb;
  localparam int unsigned W = 12;

  typedef struct {
    logic         lt, eq, gt;
    logic [W-1:0] sel;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic         c_lt, c_eq, c_gt, mode;
  logic         lt, eq, gt;
  logic [W-1:0] sel;

  int   checks = 0;
  int   failures = 0;
  bit   drv_done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  mag_cmp_minmax u_dut (
    .a_i(a), .b_i(b), .cas_lt_i(c_lt), .cas_eq_i(c_eq), .cas_gt_i(c_gt),
    .max_mode_i(mode), .lt_o(lt), .eq_o(eq), .gt_o(gt), .sel_o(sel)
  );

  // expected values come from the requirements, using the relational operators
  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [2:0] cas, input logic md, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    a = xa; b = xb; {c_lt, c_eq, c_gt} = cas; mode = md;
    e.gt  = (xa > xb) || ((xa == xb) && cas[0]);
    e.lt  = (xa < xb) || ((xa == xb) && cas[2]);
    e.eq  = (xa == xb) && cas[1];
    e.sel = md ? ((xa > xb) ? xa : xb) : ((xa < xb) ? xa : xb);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: the outputs are compared at the falling edge after each drive
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if ({lt, eq, gt} !== {e.lt, e.eq, e.gt} || sel !== e.sel) begin
          failures++;
          $display("FAIL %s: a=%h b=%h act lt/eq/gt=%b%b%b sel=%h exp lt/eq/gt=%b%b%b sel=%h",
                   e.tag, a, b, lt, eq, gt, sel, e.lt, e.eq, e.gt, e.sel);
        end
      end
    end
  end

  initial begin
    logic [W-1:0] edges [10];
    edges = '{12'h000, 12'h001, 12'h00F, 12'h010, 12'h0FF,
              12'h100, 12'h7FF, 12'h800, 12'hFFE, 12'hFFF};
    a = '0; b = '0; {c_lt, c_eq, c_gt} = 3'b010; mode = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: equal zero operands with the standalone cascade input
    drive(12'h000, 12'h000, 3'b010, 1'b0, "R3 reset");
    // R1 R2 R6 R7: every pair of boundary values in both modes
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int m = 0; m < 2; m++)
          drive(edges[i], edges[j], 3'b010, m[0], m[0] ? "R1/R2/R6 edge" : "R1/R2/R7 edge");
    // R4: upper nibble decides against the opposite lower nibbles
    drive(12'h200, 12'h1FF, 3'b010, 1'b1, "R4 top nibble gt");
    drive(12'h1FF, 12'h200, 3'b010, 1'b1, "R4 top nibble lt");
    drive(12'h350, 12'h34F, 3'b001, 1'b0, "R4 mid nibble gt");
    drive(12'h34F, 12'h350, 3'b100, 1'b0, "R4 mid nibble lt");
    // R5 R8: every cascade input combination on equal operands
    for (int c = 0; c < 8; c++)
      for (int m = 0; m < 2; m++) begin
        drive(12'hA5C, 12'hA5C, c[2:0], m[0], "R5/R8 cascade");
        drive(12'hA5C, 12'hA5B, c[2:0], m[0], "R5 cascade ignored");
      end
    // random traffic with one-hot cascade inputs
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] ra, rb;
      logic [2:0] cas;
      ra  = W'($urandom);
      rb  = (k % 8 == 0) ? ra : W'($urandom);
      cas = 3'b001 << ($urandom % 3);
      drive(ra, rb, cas, 1'($urandom), "R1/R2/R3/R6/R7 random");
    end
    @(posedge clk);
    @(posedge clk);
    drv_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!drv_done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!drv_done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: act=timeout exp=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule